// File: doc/BRIEF.md
# Saturating Latency Histogram

This block gathers statistics on request latency. Each valid latency sample is divided by a programmable scale to pick one of a fixed number of bucket counters, and that counter is incremented. Samples whose quotient lands past the last bucket are folded into the last bucket. In parallel the block keeps a running total of all sample values and a running count of samples. Every counter stops at its all-ones value instead of wrapping.

A sample moves through three pipeline stages. In CAPTURE the bucket index is computed and the sample is registered. In FETCH the current value of the target bucket is read, taking the value from COMMIT when COMMIT writes the same bucket in that cycle. In COMMIT the incremented value is written back and the total and count are updated. Each stage passes to the next on every clock edge. A valid sample moves CAPTURE to FETCH to COMMIT. An idle cycle leaves the stage empty. A clear flushes all three stages to empty and zeroes the storage. Software programs the scale through a one-cycle write strobe and reads any bucket, the total or the count through one combinational read port.

Top module: `lathist_top`

## Requirements
- R1: After reset every bucket, the total and the count read as zero, and the scale register holds zero.
- R2: With a nonzero scale register value D, a sample of latency L increments bucket floor(L / D).
- R3: With the scale register at zero, the built-in default scale DEF_SCALE is used as the divisor.
- R4: A quotient larger than NB-1 increments bucket NB-1.
- R5: A sample presented in cycle k is visible at the read port after the clock edge that ends cycle k+2 and not before. Samples on consecutive cycles to the same bucket are all counted.
- R6: Each accepted sample adds its latency to the total and adds one to the count.
- R7: Bucket counters (CNT_W bits), total (SUM_W bits) and count (NUM_W bits) each hold at all ones once reached and never wrap.
- R8: A clear zeroes all buckets, the total and the count in one cycle. It does not change the scale register.
- R9: A sample presented in the same cycle as a clear is discarded.
- R10: A scale write takes effect for samples in later cycles. A sample in the same cycle as the write uses the previous scale.
- R11: The read select `rd_kind` uses 0 for the bucket at `rd_idx`, 1 for the total and 2 for the count. Value 3, or a bucket index of NB or more, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Latency sample valid |
| smp_lat | input | LAT_W | Latency sample value |
| clr | input | 1 | Clear all statistics |
| cfg_we | input | 1 | Scale register write strobe |
| cfg_div | input | DIV_W | New scale value (0 selects default) |
| rd_kind | input | 2 | Read select: 0 bucket, 1 total, 2 count |
| rd_idx | input | $clog2(NB) | Bucket index for reads |
| rd_data | output | SUM_W | Read data, zero-extended |

## Verification
The embedded assertions check on every cycle that a committed bucket increases by exactly one over the value it held in storage, which exposes any missing forwarding between FETCH and COMMIT. They also check that saturated counters stay at all ones, that the count moves by at most one per cycle, and that a clear empties the pipeline and zeroes the totals. Only the bench's sweeps can show that the division, the default scale, clamping and the read-port encodings give the right bucket for each latency and scale value. The same holds for the two-cycle visibility latency and for the old-scale rule on a write that coincides with a sample.

// File: rtl/lathist_pkg.sv
package lathist_pkg;

    typedef enum logic [1:0] {
        RD_BUCKET = 2'd0,
        RD_TOTAL  = 2'd1,
        RD_COUNT  = 2'd2,
        RD_NONE   = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/lathist_index.sv
module lathist_index #(
    parameter int LAT_W     = 16,
    parameter int DIV_W     = 16,
    parameter int NB        = 100,
    parameter int DEF_SCALE = 30,
    parameter int IDX_W     = $clog2(NB)
) (
    input  logic [LAT_W-1:0] lat,
    input  logic [DIV_W-1:0] div,
    output logic [IDX_W-1:0] idx
);

    localparam int QW = LAT_W + DIV_W;
    localparam logic [QW-1:0] LAST_Q = QW'(NB - 1);

    logic [DIV_W-1:0] eff_div;
    logic [QW-1:0]    quot;

    always_comb begin
        eff_div = (div == '0) ? DIV_W'(DEF_SCALE) : div;
        quot    = {{DIV_W{1'b0}}, lat} / {{LAT_W{1'b0}}, eff_div};
        idx     = (quot > LAST_Q) ? IDX_W'(NB - 1) : quot[IDX_W-1:0];
    end

endmodule

// File: rtl/lathist_bank.sv
module lathist_bank #(
    parameter int NB    = 100,
    parameter int CNT_W = 32,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             s_vld,
    input  logic [IDX_W-1:0] s_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);

    logic [CNT_W-1:0] mem [NB];

    // FETCH stage registers
    logic             f_vld;
    logic [IDX_W-1:0] f_idx;
    logic [CNT_W-1:0] f_cur;
    logic [CNT_W-1:0] f_next;
    logic             fwd;

    always_comb begin
        f_next = (f_cur == '1) ? f_cur : f_cur + CNT_W'(1);
        fwd    = f_vld && (f_idx == s_idx);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            f_vld <= 1'b0;
            f_idx <= '0;
            f_cur <= '0;
        end else begin
            f_vld <= s_vld;
            f_idx <= s_idx;
            f_cur <= fwd ? f_next : mem[s_idx];
        end
    end

    // COMMIT: one write port per bucket
    for (genvar g = 0; g < NB; g++) begin : g_bkt
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mem[g] <= '0;
            end else if (f_vld && (f_idx == IDX_W'(g))) begin
                mem[g] <= f_next;
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_idx} < (IDX_W + 1)'(NB)) rd_cnt = mem[rd_idx];
        else                                   rd_cnt = '0;
    end

    // R5: commit raises the stored bucket by exactly one (fails without forwarding)
    a_r5_commit_step: assert property (@(posedge clk) disable iff (rst)
        (f_vld && !clr && mem[f_idx] != '1) |=> (mem[$past(f_idx)] == $past(mem[f_idx]) + CNT_W'(1)));

    // R7: a full bucket stays full
    a_r7_bucket_hold: assert property (@(posedge clk) disable iff (rst)
        (f_vld && !clr && mem[f_idx] == '1) |=> (mem[$past(f_idx)] == '1));

    // R8: clear empties the fetch stage and bucket zero
    a_r8_bank_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!f_vld && mem[0] == '0));

endmodule

// File: rtl/lathist_totals.sv
module lathist_totals #(
    parameter int LAT_W = 16,
    parameter int SUM_W = 48,
    parameter int NUM_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             s_vld,
    input  logic [LAT_W-1:0] s_lat,
    output logic [SUM_W-1:0] total,
    output logic [NUM_W-1:0] count
);

    logic             t_vld;
    logic [LAT_W-1:0] t_lat;
    logic [SUM_W:0]   wide_sum;

    always_comb begin
        wide_sum = {1'b0, total} + {{(SUM_W - LAT_W + 1){1'b0}}, t_lat};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            t_vld <= 1'b0;
            t_lat <= '0;
            total <= '0;
            count <= '0;
        end else begin
            t_vld <= s_vld;
            t_lat <= s_lat;
            if (t_vld) begin
                total <= wide_sum[SUM_W] ? '1 : wide_sum[SUM_W-1:0];
                if (count != '1) count <= count + NUM_W'(1);
            end
        end
    end

    // R6: the count moves by at most one per cycle
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count == $past(count) || count == $past(count) + NUM_W'(1)));

    // R7: a full total never wraps
    a_r7_total_hold: assert property (@(posedge clk) disable iff (rst)
        (total == '1 && !clr) |=> (total == '1));

    // R8: clear zeroes total and count
    a_r8_totals_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total == '0 && count == '0));

endmodule

// File: rtl/lathist_top.sv
module lathist_top
    import lathist_pkg::*;
#(
    parameter int LAT_W     = 16,
    parameter int DIV_W     = 16,
    parameter int NB        = 100,
    parameter int DEF_SCALE = 30,
    parameter int CNT_W     = 32,
    parameter int SUM_W     = 48,
    parameter int NUM_W     = 32,
    localparam int IDX_W    = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [LAT_W-1:0] smp_lat,
    input  logic             clr,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       rd_kind,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SUM_W-1:0] rd_data
);

    logic [DIV_W-1:0] div_q;
    logic [IDX_W-1:0] idx_c;

    // CAPTURE stage registers
    logic             a_vld;
    logic [IDX_W-1:0] a_idx;
    logic [LAT_W-1:0] a_lat;

    logic [CNT_W-1:0] bk_cnt;
    logic [SUM_W-1:0] total;
    logic [NUM_W-1:0] count;
    rd_kind_e         kind;

    lathist_index #(
        .LAT_W(LAT_W), .DIV_W(DIV_W), .NB(NB), .DEF_SCALE(DEF_SCALE), .IDX_W(IDX_W)
    ) u_index (
        .lat(smp_lat), .div(div_q), .idx(idx_c)
    );

    always_ff @(posedge clk) begin
        if (rst)         div_q <= '0;
        else if (cfg_we) div_q <= cfg_div;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            a_vld <= 1'b0;
            a_idx <= '0;
            a_lat <= '0;
        end else begin
            a_vld <= smp_vld;
            a_idx <= idx_c;
            a_lat <= smp_lat;
        end
    end

    lathist_bank #(
        .NB(NB), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst(rst), .clr(clr),
        .s_vld(a_vld), .s_idx(a_idx),
        .rd_idx(rd_idx), .rd_cnt(bk_cnt)
    );

    lathist_totals #(
        .LAT_W(LAT_W), .SUM_W(SUM_W), .NUM_W(NUM_W)
    ) u_totals (
        .clk(clk), .rst(rst), .clr(clr),
        .s_vld(a_vld), .s_lat(a_lat),
        .total(total), .count(count)
    );

    always_comb begin
        kind = rd_kind_e'(rd_kind);
        unique case (kind)
            RD_BUCKET: rd_data = SUM_W'(bk_cnt);
            RD_TOTAL:  rd_data = total;
            RD_COUNT:  rd_data = SUM_W'(count);
            default:   rd_data = '0;
        endcase
    end

    // R9: a sample alongside clear never enters the pipeline
    a_r9_drop_on_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !a_vld);

    // R10: scale register only changes on a write strobe
    a_r10_scale_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(div_q));

    // R8: clear leaves the scale register untouched
    a_r8_scale_kept: assert property (@(posedge clk) disable iff (rst)
        (clr && !cfg_we) |=> (div_q == $past(div_q)));

endmodule

// File: tb/sim_lathist_top.sv
module sim_lathist_top;

    localparam int LAT_W = 8;
    localparam int DIV_W = 4;
    localparam int NB    = 6;
    localparam int DEF   = 3;
    localparam int CNT_W = 4;
    localparam int SUM_W = 10;
    localparam int NUM_W = 5;
    localparam int IDX_W = $clog2(NB);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic [LAT_W-1:0] smp_lat = '0;
    logic             clr = 1'b0;
    logic             cfg_we = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [1:0]       rd_kind = 2'd0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [SUM_W-1:0] rd_data;

    int total_chk = 0;
    int bad_chk   = 0;
    int exp_bkt [NB];
    int exp_sum;
    int exp_num;
    int cur_div;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lathist_top #(
        .LAT_W(LAT_W), .DIV_W(DIV_W), .NB(NB), .DEF_SCALE(DEF),
        .CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W)
    ) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_lat(smp_lat), .clr(clr),
        .cfg_we(cfg_we), .cfg_div(cfg_div), .rd_kind(rd_kind), .rd_idx(rd_idx),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total_chk++;
        if (got != exp) begin
            bad_chk++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic rd(input int kind, input int idx, output int val);
        rd_kind = 2'(kind);
        rd_idx  = IDX_W'(idx);
        #1;
        val = int'(rd_data);
    endtask

    function automatic int model_idx(input int lat, input int d);
        int e = (d == 0) ? DEF : d;
        int i = lat / e;
        return (i > NB - 1) ? NB - 1 : i;
    endfunction

    task automatic model_add(input int lat, input int d);
        int i = model_idx(lat, d);
        if (exp_bkt[i] < (1 << CNT_W) - 1) exp_bkt[i]++;
        exp_sum = (exp_sum + lat > (1 << SUM_W) - 1) ? (1 << SUM_W) - 1 : exp_sum + lat;
        if (exp_num < (1 << NUM_W) - 1) exp_num++;
    endtask

    task automatic model_zero();
        for (int i = 0; i < NB; i++) exp_bkt[i] = 0;
        exp_sum = 0;
        exp_num = 0;
    endtask

    // called right after a negedge: one sample in this cycle
    task automatic send(input int lat);
        smp_vld = 1'b1;
        smp_lat = LAT_W'(lat);
        @(negedge clk);
        smp_vld = 1'b0;
        model_add(lat, cur_div);
    endtask

    task automatic settle();
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_zero();
    endtask

    task automatic set_div(input int d);
        cfg_we  = 1'b1;
        cfg_div = DIV_W'(d);
        @(negedge clk);
        cfg_we  = 1'b0;
        cur_div = d;
    endtask

    task automatic check_all(input string req);
        int v;
        for (int i = 0; i < NB; i++) begin
            rd(0, i, v);
            chk(req, $sformatf("bucket %0d", i), v, exp_bkt[i]);
        end
        rd(1, 0, v);
        chk(req, "total", v, exp_sum);
        rd(2, 0, v);
        chk(req, "count", v, exp_num);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad_chk++;
            total_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

    initial begin
        int v;
        model_zero();
        cur_div = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_all("R1");

        // R3 and R5: default scale, back-to-back samples into shared buckets
        for (int l = 0; l < 3 * NB; l++) send(l);
        settle();
        check_all("R3");

        // R5: visibility two edges after capture
        do_clear();
        settle();
        smp_vld = 1'b1;
        smp_lat = 8'd5;
        @(negedge clk);
        smp_vld = 1'b0;
        rd(2, 0, v);
        chk("R5", "count one cycle after sample", v, 0);
        @(negedge clk);
        rd(2, 0, v);
        chk("R5", "count two cycles after sample", v, 0);
        @(negedge clk);
        rd(2, 0, v);
        chk("R5", "count three cycles after sample", v, 1);

        // R2, R4, R6, R7: sweep every nonzero scale
        for (int d = 1; d < (1 << DIV_W); d++) begin
            do_clear();
            set_div(d);
            for (int l = 0; l <= 30; l++) send(l);
            settle();
            check_all("R2");
        end

        // R7 and R4: saturation of bucket, total and count
        do_clear();
        set_div(0);
        for (int k = 0; k < 40; k++) send(200);
        settle();
        check_all("R7");

        // R8: clear zeroes statistics but keeps scale
        set_div(2);
        send(7);
        settle();
        do_clear();
        settle();
        check_all("R8");
        send(4);
        settle();
        rd(0, 2, v);
        chk("R8", "scale kept after clear, bucket 2", v, 1);

        // R9: sample in the same cycle as clear is dropped
        settle();
        clr     = 1'b1;
        smp_vld = 1'b1;
        smp_lat = 8'd1;
        @(negedge clk);
        clr     = 1'b0;
        smp_vld = 1'b0;
        model_zero();
        settle();
        check_all("R9");

        // R10: write coinciding with a sample uses the old scale
        cfg_we  = 1'b1;
        cfg_div = 4'd4;
        smp_vld = 1'b1;
        smp_lat = 8'd8;
        @(negedge clk);
        cfg_we  = 1'b0;
        model_add(8, 2);
        cur_div = 4;
        send(8);
        settle();
        check_all("R10");

        // R11: unused select and out-of-range index read zero
        rd(3, 0, v);
        chk("R11", "select 3", v, 0);
        rd(0, NB, v);
        chk("R11", "index NB", v, 0);
        rd(0, (1 << IDX_W) - 1, v);
        chk("R11", "top index", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule